// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device end of a four-wire serial flash link, reduced to the two read commands. A host selects the device by pulling the active-low select line low. It clocks an 8-bit opcode and then a 24-bit address into the serial input on rising serial-clock edges, most significant bit first. The block then streams bytes from its internal byte-wide array on the serial output, most significant bit first. The stream continues until the host releases the select line.

The plain read opcode (03h) returns data right after the address. The fast read opcode (0Bh) first lets eight more clocks pass whose input value is ignored. The read pointer steps by one after every byte and wraps from the top of the array back to zero. Any other opcode makes the block stay silent until the next deselect.

The design is written for an FPGA fabric. The serial pins are brought into the system clock domain through synchronisers, and both serial-clock edges are detected there. The array is written through a plain load port and read through a registered read port, so it maps onto block RAM. The serial clock may idle low or high. Serial-clock edges must lie at least four system clocks apart.

Top module: `sflash_read_slave`

## Requirements
- R1: Opcode 03h followed by a 24-bit address (most significant bit first) returns the array byte at that address. Its first bit is driven after the first falling serial-clock edge that follows the 32nd rising edge.
- R2: Opcode 0Bh with an address returns data only after eight further rising edges. The input values during those eight clocks have no effect on the data.
- R3: Each output byte is sent most significant bit first. The output bit changes only after a falling serial-clock edge is detected, so it is stable when the host samples it at the next rising edge.
- R4: While select stays low, bytes follow one another with no gap, from consecutive addresses.
- R5: Only the low AW address bits select a byte; higher address bits are ignored. After byte 2^AW-1 the pointer wraps to 0.
- R6: The output enable is low during the opcode, address and dummy phases, and at all times while select is high.
- R7: An opcode other than 03h or 0Bh keeps the output enable low for the rest of that selection. The next selection is decoded normally.
- R8: Raising select at any point, even within a byte, ends the read. The next selection starts again at the opcode phase.
- R9: Both serial-clock idle levels work: low (mode 0) and high (mode 3). A falling edge that comes before the first rising edge is ignored.
- R10: After reset the output enable and the output bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low device select from the host |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the serial data pad (1 = drive) |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | AW | Array load address |
| ld_data | input | 8 | Array load data |

## Verification
The bench checks reads that start at the last byte of the array. A design that forgets the wrap would return the wrong bytes after the top address, or would stall there. Fast reads are sent with random dummy bits and random high address bits; a design that decoded either would return bytes from the wrong place. Some selections are dropped in the middle of a byte, and some carry a bad opcode. After these the bench checks that the output enable falls and that the next read is decoded from a clean state. Mode 3 transfers start with a falling edge before any rising edge. A design that counted that edge would be off by one bit on every byte.

// File: rtl/sflash_read_pkg.sv
package sflash_read_pkg;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_t;
endpackage

// File: rtl/sflash_pin_sync.sv
// Brings the serial pins into the system clock domain and flags sck edges.
module sflash_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_q,
  output logic si_q,
  output logic sck_rise,
  output logic sck_fall
);
  // bit 2 = select, bit 1 = clock, bit 0 = data
  localparam logic [2:0] RST_VAL = 3'b100;

  logic [2:0] st [STAGES];
  logic       sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      sck_prev <= 1'b0;
    end else begin
      st[0] <= {cs_n, sck, si};
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      sck_prev <= st[STAGES-1][1];
    end
  end

  assign cs_q     = st[STAGES-1][2];
  assign si_q     = st[STAGES-1][0];
  assign sck_rise = st[STAGES-1][1] & ~sck_prev;
  assign sck_fall = ~st[STAGES-1][1] & sck_prev;
endmodule

// File: rtl/sflash_byte_array.sv
// Byte array with a load port and a registered read port (block RAM style).
module sflash_byte_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sflash_read_seq.sv
// Command decode, address capture, dummy count and output shifting.
module sflash_read_seq
  import sflash_read_pkg::*;
#(
  parameter int AW         = 8,
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_CLKS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_q,
  input  logic          si_q,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output phase_t        phase,
  output logic          so,
  output logic          so_oe
);
  localparam int CW   = $clog2(ADDR_BITS + 1);
  localparam int SR_W = (AW > 8) ? AW : 8;

  logic [CW-1:0]   cnt;
  logic [SR_W-2:0] sr;
  logic [SR_W-1:0] sr_next;
  logic            fast;
  logic [2:0]      bidx;
  logic [6:0]      obuf;

  assign sr_next = {sr, si_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD;
      cnt   <= '0;
      sr    <= '0;
      fast  <= 1'b0;
      ptr   <= '0;
      bidx  <= '0;
      obuf  <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (cs_q) begin
      phase <= PH_CMD;
      cnt   <= '0;
      bidx  <= '0;
      so_oe <= 1'b0;
    end else if (sck_rise) begin
      case (phase)
        PH_CMD: begin
          sr  <= sr_next[SR_W-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            if (sr_next[7:0] == OP_READ) begin
              phase <= PH_ADDR;
              fast  <= 1'b0;
            end else if (sr_next[7:0] == OP_FAST) begin
              phase <= PH_ADDR;
              fast  <= 1'b1;
            end else begin
              phase <= PH_IGNORE;
            end
          end
        end
        PH_ADDR: begin
          sr  <= sr_next[SR_W-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ADDR_BITS - 1)) begin
            cnt   <= '0;
            ptr   <= sr_next[AW-1:0];
            bidx  <= '0;
            phase <= fast ? PH_DUMMY : PH_DATA;
          end
        end
        PH_DUMMY: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DUMMY_CLKS - 1)) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end
        end
        default: ;
      endcase
    end else if (sck_fall && phase == PH_DATA) begin
      so_oe <= 1'b1;
      bidx  <= bidx + 1'b1;
      if (bidx == 3'd0) begin
        so   <= rd_data[7];
        obuf <= rd_data[6:0];
        ptr  <= ptr + 1'b1;
      end else begin
        so   <= obuf[6];
        obuf <= {obuf[5:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sflash_read_slave.sv
module sflash_read_slave
  import sflash_read_pkg::*;
#(
  parameter int AW          = 8,
  parameter int ADDR_BITS   = 24,
  parameter int DUMMY_CLKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data
);
  logic          cs_q, si_q, sck_rise, sck_fall;
  logic [AW-1:0] ptr;
  logic [7:0]    rd_data;
  phase_t        phase;

  sflash_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_q(cs_q), .si_q(si_q), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  sflash_byte_array #(.AW(AW)) u_array (
    .clk(clk), .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  sflash_read_seq #(
    .AW(AW), .ADDR_BITS(ADDR_BITS), .DUMMY_CLKS(DUMMY_CLKS)
  ) u_seq (
    .clk(clk), .rst(rst), .cs_q(cs_q), .si_q(si_q),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rd_data(rd_data),
    .ptr(ptr), .phase(phase), .so(so), .so_oe(so_oe)
  );
endmodule

// File: rtl/sflash_read_chk.sv
module sflash_read_chk
  import sflash_read_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_q,
  input logic          sck_fall,
  input phase_t        phase,
  input logic [AW-1:0] ptr,
  input logic          so,
  input logic          so_oe
);
  AST_DESELECT_TRISTATE: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !so_oe); // R6

  AST_OE_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> phase == PH_DATA); // R6

  AST_SO_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(so)); // R3

  AST_IGNORE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE && !cs_q) |=> phase == PH_IGNORE); // R7

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && !cs_q) |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1)); // R4
endmodule

bind sflash_read_slave sflash_read_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .sck_fall(sck_fall),
  .phase(phase), .ptr(ptr), .so(so), .so_oe(so_oe)
);

// File: tb/sflash_read_slave_tb.sv
module sflash_read_slave_tb;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic          so, so_oe;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;

  logic [7:0] model [DEPTH];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  sflash_read_slave #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [23:0] a, input int i);
    logic [AW-1:0] idx;
    idx = a[AW-1:0] + AW'(i);
    return model[idx];
  endfunction

  task automatic tick();
    repeat (HALF) @(negedge clk);
  endtask

  bit oe_seen;

  task automatic put_bit(input bit b);
    sck = 1'b0; si = b;
    tick();
    if (so_oe !== 1'b0) oe_seen = 1'b1;
    sck = 1'b1;
    tick();
  endtask

  task automatic get_bit(output bit v, output bit oe);
    sck = 1'b0; si = 1'($urandom);
    tick();
    v = so; oe = so_oe;
    sck = 1'b1;
    tick();
  endtask

  // abort_bits < 0: read nbytes whole bytes; otherwise drop select after that many bits
  task automatic xfer(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                      input bit mode3, input int abort_bits, input string req);
    bit v, oe;
    logic [7:0] got;
    bit good;
    good = (op == 8'h03) || (op == 8'h0B);
    oe_seen = 1'b0;
    sck = mode3; cs_n = 1'b1;
    tick();
    cs_n = 1'b0;
    tick();
    for (int i = 7; i >= 0; i--) put_bit(op[i]);
    for (int i = 23; i >= 0; i--) put_bit(addr[i]);
    if (op == 8'h0B)
      for (int i = 0; i < 8; i++) put_bit(1'($urandom)); // R2 dummy bits ignored
    chk(!oe_seen, "R6", "oe during cmd/addr/dummy", 32'(oe_seen), 0);
    if (!good) begin
      for (int i = 0; i < 16; i++) put_bit(1'($urandom));
      chk(!oe_seen, "R7", "oe after bad opcode", 32'(oe_seen), 0);
    end else if (abort_bits >= 0) begin
      for (int i = 0; i < abort_bits; i++) get_bit(v, oe);
    end else begin
      for (int b = 0; b < nbytes; b++) begin
        got = '0;
        for (int i = 0; i < 8; i++) begin
          get_bit(v, oe);
          got = {got[6:0], v};
          chk(oe, req, "oe during data (R4)", 32'(oe), 1);
        end
        chk(got == exp_byte(addr, b), req, $sformatf("byte %0d of read at %0h", b, addr),
            32'(got), 32'(exp_byte(addr, b)));
      end
    end
    if (!mode3) begin sck = 1'b0; tick(); end
    cs_n = 1'b1;
    tick();
    chk(so_oe === 1'b0, "R8", "oe after deselect", 32'(so_oe), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk(so_oe === 1'b0 && so === 1'b0, "R10", "reset outputs", {so_oe, so}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(so_oe === 1'b0, "R10", "oe after reset release", 32'(so_oe), 0);

    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'($urandom);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = model[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);

    xfer(8'h03, 24'h000010, 3, 1'b0, -1, "R1");            // R1 R3 plain read
    xfer(8'h0B, 24'h000040, 3, 1'b0, -1, "R2");            // R2 fast read
    xfer(8'h03, 24'h0000FE, 4, 1'b0, -1, "R5");            // R5 wrap top to zero
    xfer(8'h0B, 24'hABCDFF, 3, 1'b1, -1, "R5");            // R5 high bits ignored, wrap
    xfer(8'h03, 24'h000080, 2, 1'b1, -1, "R9");            // R9 mode 3
    xfer(8'h9F, 24'h000000, 0, 1'b0, -1, "R7");            // R7 bad opcode
    xfer(8'h03, 24'h000022, 2, 1'b0, -1, "R7");            // R7 next selection decodes
    xfer(8'h0B, 24'h000033, 0, 1'b0, 13, "R8");            // R8 abort mid-byte
    xfer(8'h03, 24'h000033, 2, 1'b1, -1, "R8");            // R8 restart clean
    xfer(8'h03, 24'h0000C0, 10, 1'b0, -1, "R4");           // R4 long stream

    for (int t = 0; t < 20; t++) begin
      logic [7:0] op;
      op = ($urandom % 2) ? 8'h0B : 8'h03;
      xfer(op, 24'($urandom), 1 + int'($urandom % 5), 1'($urandom), -1,
           op == 8'h0B ? "R2" : "R1");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule